// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets software drive any serial flash command through a single generic transfer. Software stages the whole transaction in a 128-word write buffer over a plain register bus. Word 0 carries the command byte and any address bytes, and payload words for a page write follow from word 1 on. Software then writes a byte count to the control register. The engine raises chip select and clocks that many bytes out on MOSI. While it does so it captures the same number of bytes from MISO into a 128-word read buffer. Software polls the busy bit and then reads the response back.

The bus port has no back-pressure. A request is taken in the cycle it is presented. Read data is registered and appears on `bus_rdata` in the following cycle, where it holds until the next read. The serial side runs SPI mode 0, with the clock derived from the system clock by the parameter `CLK_DIV`.

Top module: `sflash_cmd_engine`

## Requirements
- R1: A bus write to word address 0x1000 + i (i = 0..127) stores the 32-bit value in write-buffer word i. A bus read of the same address returns that value on `bus_rdata` in the cycle after the read request.
- R2: Word addresses 0x1080 + i (i = 0..127) read read-buffer word i. Bus writes there are ignored and leave the stored word unchanged.
- R3: A bus write to the control register (word address 0x001) while idle starts a transfer of `bus_wdata[8:0]` + 1 bytes. A control read returns 1 in bit 0 while a transfer is in progress and 0 once it ends. All other bits read 0.
- R4: Transmitted byte k is taken from write-buffer word k/4, in bits [31-8*(k%4) -: 8], so word 0's top byte is the command. Each byte is sent most significant bit first. Counts up to 512 bytes are supported.
- R5: SCK idles low and has a period of `CLK_DIV` clocks, low in the first half and high in the second. MOSI changes only while SCK is low, and MISO is sampled on the rising edge. The first rising edge comes `CLK_DIV` + `CLK_DIV`/2 clocks after chip select falls.
- R6: For an N-byte transfer, `cs_n` stays low for exactly (8N+2)*`CLK_DIV` clocks. This gives one SCK period before the first bit and one after the last. The last SCK high ends `CLK_DIV` clocks before `cs_n` rises.
- R7: The byte received during byte period k is written to read-buffer word k/4 at the same bit position as in R4, MSB first. Read-buffer bytes outside the transfer keep their previous values.
- R8: A control write arriving while a transfer is in progress is ignored. This includes the final clock of the trailing period. The running transfer's length is unchanged and no new transfer follows.
- R9: After reset the engine is idle, `cs_n` is 1, `sck` is 0 and a control read returns 0.
- R10: A bus read of any address outside the control register and the two buffers returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Two functions can meet in one cycle: the sequencer's return to idle at the end of the trailing period, and a new control write. The bench counts cycles from the start edge. It lands a second control write exactly on the last clock in which chip select is still low, and a further control write partway through another transfer. Both are judged at the pins: the chip-select low time must equal the length from the original count, and chip select must stay high afterwards. An accepted restart would show up as a longer or repeated low period.

// File: rtl/sflash_cmd_pkg.sv
package sflash_cmd_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LEAD  = 2'd1,
    SQ_SHIFT = 2'd2,
    SQ_TRAIL = 2'd3
  } sq_state_e;

  localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/sflash_txbuf.sv
module sflash_txbuf #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] bus_idx,
  output logic [DW-1:0] bus_word,
  input  logic [IW-1:0] eng_idx,
  output logic [DW-1:0] eng_word
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign bus_word = mem[bus_idx];
  assign eng_word = mem[eng_idx];
endmodule

// File: rtl/sflash_rxbuf.sv
module sflash_rxbuf #(
  parameter int unsigned WORDS = 128,
  localparam int unsigned IW   = $clog2(WORDS),
  localparam int unsigned PW   = IW + 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] byte_pos,
  input  logic [7:0]    byte_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_word
);
  logic [3:0][7:0] mem [WORDS];

  // byte 0 of a word lands in the top lane
  always_ff @(posedge clk) begin
    if (we) mem[byte_pos[PW-1:2]][~byte_pos[1:0]] <= byte_data;
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_cmd_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned CNT_W   = 9,
  localparam int unsigned PH_W   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1,
  localparam int unsigned HALF   = CLK_DIV / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  output logic [CNT_W-3:0] tx_idx,
  input  logic [31:0]      tx_word,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             rx_we,
  output logic [CNT_W-1:0] rx_pos,
  output logic [7:0]       rx_byte
);
  sq_state_e        state;
  logic [PH_W-1:0]  ph;
  logic [2:0]       bit_idx;
  logic [CNT_W-1:0] byte_idx;
  logic [CNT_W-1:0] last_idx;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_byte;
  logic             ph_end;

  assign ph_end = (ph == PH_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ph       <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      last_idx <= '0;
      rx_sh    <= '0;
    end else begin
      if (state != SQ_IDLE) ph <= ph_end ? '0 : ph + 1'b1;
      unique case (state)
        SQ_IDLE: if (start) begin
          state    <= SQ_LEAD;
          ph       <= '0;
          bit_idx  <= '0;
          byte_idx <= '0;
          last_idx <= start_cnt;
        end
        SQ_LEAD: if (ph_end) state <= SQ_SHIFT;
        SQ_SHIFT: begin
          if (ph == PH_W'(HALF)) rx_sh <= {rx_sh[6:0], miso};
          if (ph_end) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) begin
              if (byte_idx == last_idx) state <= SQ_TRAIL;
              else byte_idx <= byte_idx + 1'b1;
            end
          end
        end
        SQ_TRAIL: if (ph_end) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state != SQ_IDLE);
  assign cs_n    = ~busy;
  assign sck     = (state == SQ_SHIFT) && (ph >= PH_W'(HALF));
  assign tx_idx  = byte_idx[CNT_W-1:2];
  assign tx_byte = tx_word[{~byte_idx[1:0], 3'b000} +: 8];
  assign mosi    = ((state == SQ_LEAD) || (state == SQ_SHIFT)) ? tx_byte[~bit_idx] : 1'b0;
  assign rx_we   = (state == SQ_SHIFT) && ph_end && (bit_idx == 3'd7);
  assign rx_pos  = byte_idx;
  assign rx_byte = rx_sh;

  p_sck_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  p_busy_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_restart_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(last_idx));
  p_byte_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_idx <= last_idx));
  p_cs_edges_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) || $rose(cs_n)) |-> !sck);
  p_store_once_per_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |=> !rx_we);
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine #(
  parameter int unsigned CLK_DIV   = 4,
  parameter int unsigned BUF_WORDS = 128,
  parameter int unsigned ADDR_W    = 13,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h0001,
  parameter logic [ADDR_W-1:0] TXB_BASE  = 13'h1000,
  parameter logic [ADDR_W-1:0] RXB_BASE  = 13'h1080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int unsigned IW    = $clog2(BUF_WORDS);
  localparam int unsigned CNT_W = IW + 2;

  logic             txb_hit, rxb_hit, ctrl_hit;
  logic             start, busy;
  logic [31:0]      txb_bus_word, txb_eng_word, rxb_bus_word;
  logic [CNT_W-3:0] tx_idx;
  logic             rx_we;
  logic [CNT_W-1:0] rx_pos;
  logic [7:0]       rx_byte;

  assign txb_hit  = (bus_addr[ADDR_W-1:IW] == TXB_BASE[ADDR_W-1:IW]);
  assign rxb_hit  = (bus_addr[ADDR_W-1:IW] == RXB_BASE[ADDR_W-1:IW]);
  assign ctrl_hit = (bus_addr == CTRL_ADDR);
  assign start    = bus_en && bus_we && ctrl_hit;

  sflash_txbuf #(.WORDS(BUF_WORDS), .DW(32)) u_txbuf (
    .clk      (clk),
    .wr_en    (bus_en && bus_we && txb_hit),
    .wr_idx   (bus_addr[IW-1:0]),
    .wr_data  (bus_wdata),
    .bus_idx  (bus_addr[IW-1:0]),
    .bus_word (txb_bus_word),
    .eng_idx  (tx_idx),
    .eng_word (txb_eng_word)
  );

  sflash_rxbuf #(.WORDS(BUF_WORDS)) u_rxbuf (
    .clk       (clk),
    .we        (rx_we),
    .byte_pos  (rx_pos),
    .byte_data (rx_byte),
    .rd_idx    (bus_addr[IW-1:0]),
    .rd_word   (rxb_bus_word)
  );

  sflash_seq #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_cnt (bus_wdata[CNT_W-1:0]),
    .tx_idx    (tx_idx),
    .tx_word   (txb_eng_word),
    .busy      (busy),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .miso      (miso),
    .rx_we     (rx_we),
    .rx_pos    (rx_pos),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      if (ctrl_hit)     bus_rdata <= {31'd0, busy};
      else if (txb_hit) bus_rdata <= txb_bus_word;
      else if (rxb_hit) bus_rdata <= rxb_bus_word;
      else              bus_rdata <= '0;
    end
  end

  p_ctrl_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_en && !bus_we && ctrl_hit) |-> (bus_rdata[31:1] == 31'd0));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_en && !bus_we && !ctrl_hit && !txb_hit && !rxb_hit) |-> (bus_rdata == 32'd0));
endmodule

// File: tb/sim_sflash_cmd_engine.sv
`timescale 1ns/1ps
module sim_sflash_cmd_engine;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam logic [12:0] CTRL = 13'h0001;
  localparam logic [12:0] TXB  = 13'h1000;
  localparam logic [12:0] RXB  = 13'h1080;

  // buffer readback vectors: {address, data}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {13'h1000, 32'hA5A5_5A5A},
    {13'h107F, 32'h0123_4567},
    {13'h1040, 32'hFFFF_FFFF},
    {13'h1001, 32'h0000_0000},
    {13'h1013, 32'h8000_0001},
    {13'h107E, 32'hDEAD_BEEF}
  };

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, cs_n, mosi, miso = 0;

  int n_chk = 0, n_fail = 0;
  int m_len, m_first, m_last, m_bad;
  logic [31:0] rd;

  always #5 clk = ~clk;

  sflash_cmd_engine #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  // flash responder: byte 0 = 0xC0 + transfer number, read-ID gives EF 40 18, else k^0x3C
  int r_bits = 0, r_txn = 0;
  logic [7:0] r_sh = 0, r_cmd = 0;
  logic [7:0] r_log [64];

  function automatic logic [7:0] resp(int k, int txn, logic [7:0] cmd);
    if (k == 0) return 8'hC0 + txn[7:0];
    if (cmd == 8'h9F && k == 1) return 8'hEF;
    if (cmd == 8'h9F && k == 2) return 8'h40;
    if (cmd == 8'h9F && k == 3) return 8'h18;
    return k[7:0] ^ 8'h3C;
  endfunction

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) r_bits = 0;
    else begin
      r_sh = {r_sh[6:0], mosi};
      r_bits++;
      if (r_bits % 8 == 0) begin
        if (r_bits / 8 <= 64) r_log[r_bits/8 - 1] = r_sh;
        if (r_bits == 8) r_cmd = r_sh;
      end
    end
  end

  always @(negedge sck or negedge cs_n) begin
    if (!cs_n) begin
      logic [7:0] b;
      if (r_bits == 0) r_txn++;
      b = resp(r_bits / 8, r_txn, r_cmd);
      miso = b[7 - (r_bits % 8)];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [12:0] a, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [12:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  // start a transfer, optionally inject a control write at sample stray_at
  task automatic run_xfer(logic [8:0] cnt, int stray_at, logic [8:0] stray_cnt);
    int n;
    bus_write(CTRL, {23'd0, cnt});
    n = 1; m_len = 0; m_first = 0; m_last = 0; m_bad = 0;
    while (n < 20000) begin
      if (cs_n) break;
      m_len++;
      if (sck && m_first == 0) m_first = n;
      if (sck) m_last = n;
      if (n == stray_at) begin
        bus_en = 1; bus_we = 1; bus_addr = CTRL; bus_wdata = {23'd0, stray_cnt};
      end else begin
        bus_en = 0; bus_we = 0;
      end
      @(negedge clk);
      n++;
    end
    bus_en = 0; bus_we = 0;
    for (int i = 0; i < 3*DIV; i++) begin
      if (!cs_n || sck) m_bad++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] pdata(int i);
    return 32'h1020_3040 + i * 32'h0101_0101;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state
    chk("R9 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R9 sck", {31'd0, sck}, 32'd0);
    bus_read(CTRL, rd);
    chk("R9 ctrl idle", rd, 32'd0);

    // R1: vector table walk
    for (int v = 0; v < NV; v++) begin
      bus_write(VEC[v][44:32], VEC[v][31:0]);
    end
    for (int v = 0; v < NV; v++) begin
      bus_read(VEC[v][44:32], rd);
      chk("R1 txbuf readback", rd, VEC[v][31:0]);
    end

    // R10: unmapped
    bus_read(13'h0040, rd);
    chk("R10 unmapped", rd, 32'd0);

    // read-ID, 4 bytes, stray start mid-transfer (R8)
    bus_write(TXB, 32'h9F00_0000);
    run_xfer(9'd3, 20, 9'h1FF);
    t = (8*4 + 2) * DIV;
    chk("R6 readid cs low length", m_len, t);
    chk("R8 mid stray no restart", m_bad, 0);
    chk("R5 first sck rise", m_first, DIV + HALF + 1);
    chk("R6 last sck high", m_last, DIV + 8*4*DIV);
    chk("R4 readid cmd out", {r_log[0], r_log[1], r_log[2], r_log[3]}, 32'h9F00_0000);
    bus_read(RXB, rd);
    chk("R7 readid response", rd, 32'hC1EF_4018);

    // page program, 20 bytes, stray start on final clock of trailing period (R8)
    bus_write(TXB, 32'h0200_1200);
    for (int i = 1; i <= 4; i++) bus_write(TXB + 13'(i), pdata(i));
    t = (8*20 + 2) * DIV;
    run_xfer(9'd19, t, 9'd0);
    chk("R8 final-cycle stray length", m_len, t);
    chk("R8 final-cycle stray no restart", m_bad, 0);
    chk("R4 page header out", {r_log[0], r_log[1], r_log[2], r_log[3]}, 32'h0200_1200);
    for (int i = 1; i <= 4; i++) begin
      chk("R4 page payload out", {r_log[4*i], r_log[4*i+1], r_log[4*i+2], r_log[4*i+3]}, pdata(i));
    end
    bus_read(RXB, rd);
    chk("R7 page rx word0", rd, 32'hC23D_3E3F);
    for (int w = 1; w < 5; w++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[31-8*b -: 8] = 8'(4*w + b) ^ 8'h3C;
      bus_read(RXB + 13'(w), rd);
      chk("R7 page rx word", rd, e);
    end

    // single byte: only top lane of word 0 changes
    bus_write(TXB, 32'h0500_0000);
    run_xfer(9'd0, 0, 9'd0);
    chk("R6 one byte length", m_len, 10*DIV);
    bus_read(RXB, rd);
    chk("R7 one byte partial word", rd, 32'hC33D_3E3F);
    bus_read(RXB + 13'd1, rd);
    chk("R7 untouched word", rd, 32'h3839_3A3B);

    // R2: read buffer ignores writes
    bus_write(RXB, 32'hDEAD_BEEF);
    bus_read(RXB, rd);
    chk("R2 rxbuf write ignored", rd, 32'hC33D_3E3F);

    // R3: busy bit during and after
    bus_write(CTRL, 32'd1);
    bus_read(CTRL, rd);
    chk("R3 busy during", rd, 32'd1);
    while (!cs_n) @(negedge clk);
    bus_read(CTRL, rd);
    chk("R3 busy after", rd, 32'd0);

    // R4: full 512-byte count
    run_xfer(9'h1FF, 0, 9'd0);
    chk("R4 max count length", m_len, (8*512 + 2) * DIV);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule